// File: doc/BRIEF.md
# Reservation and conditional-store controller

This block sits in a load-store pipeline stage and keeps a single address reservation. A load flagged as reserving records the cache-line address it touched. A later store flagged as conditional may only go ahead if that reservation is still valid and points at the same line. Whatever the outcome, the conditional store consumes the reservation. A store that goes ahead pulses a per-line write enable, standing in for the cache write, in its request cycle. It then performs one single-beat write on a simple bus with cycle, strobe, write and acknowledge. A store that fails never touches the cache or the bus. It completes one cycle later on its own path.

Each finished instruction produces a one-cycle completion pulse with a record flag and a store-done flag. When the record flag is set, the block also produces a 4-bit condition value for condition field 0. That value carries store-done in bit 1 and the sticky summary-overflow input in bit 0. While a bus write is outstanding, the block raises a stall output. The requester must not present a request while stall is high.

Top module: `lrsc_ctrl`

## Requirements
- R1: Reset (active-low, synchronous) leaves the reservation invalid, the bus idle (cycle, strobe and write low), stall low and no completion pulse.
- R2: After a reserving load, a conditional store to any byte of the same line (address bits at and above LINE_OFF equal) succeeds. It raises line_we in its request cycle, performs a bus write and completes with store-done 1.
- R3: A conditional store whose line differs from a valid reservation fails. It gives no line_we and no bus cycle, and stall stays low. It completes exactly one cycle after the request with done_valid 1, store-done 0 and the record flag equal to the request's.
- R4: A conditional store with no valid reservation fails in the same way as in R3.
- R5: Every conditional store clears the reservation, successful or not, so a second conditional store without a new reserving load fails.
- R6: Reset clears the reservation even when a reserving load is presented in the same cycle.
- R7: line_we is high exactly in the request cycle of a store that is not cancelled, and never for loads.
- R8: A store that proceeds raises bus cycle, strobe and write from the cycle after the request until the cycle acknowledge is seen, inclusive. During that time stall is high and the bus address equals the request address with its 3 low bits forced to zero. Bus data equals the request data.
- R9: A store completes in the cycle after acknowledge with done_valid 1, store-done 1 and the record flag taken from the request.
- R10: Any load completes in the cycle after its request with done_valid 1, record flag 0 and store-done 0.
- R11: When done_valid and the record flag are both 1, cr0_we is 1 and cr0_field is {0, 0, store-done, so_flag}. Otherwise cr0_we is 0 and cr0_field is 0.
- R12: Plain loads and plain stores (reserve flag 0) neither set nor clear the reservation.
- R13: The internal load-done, failed-store and bus-done completion flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_load | input | 1 | 1 for a load, 0 for a store |
| req_reserve | input | 1 | Reserving load or conditional store |
| req_rc | input | 1 | Record condition result |
| req_addr | input | 64 | Byte address |
| req_data | input | 64 | Store data |
| so_flag | input | 1 | Sticky summary overflow |
| stall | output | 1 | Bus write outstanding; hold requests |
| line_we | output | 1 | Cache line write enable |
| bus_cyc | output | 1 | Bus cycle |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write |
| bus_adr | output | 64 | Bus address, 8-byte aligned |
| bus_dat | output | 64 | Bus write data |
| bus_ack | input | 1 | Bus acknowledge |
| done_valid | output | 1 | Instruction completes this cycle |
| done_rc | output | 1 | Record flag of the completion |
| done_store_done | output | 1 | Store was performed |
| cr0_we | output | 1 | Condition field 0 write enable |
| cr0_field | output | 4 | Condition value |

## Verification
Conditional stores are tried in four situations. The first matches the reserved line at a different byte offset, which shows that comparison stops at the line boundary. The second hits a different line while the reservation is valid, which isolates the address compare. The third runs with no reservation at all, which isolates the valid bit. The fourth repeats a store after a success or a failure, which shows that every conditional store consumes the reservation. Plain loads and stores placed between a reserving load and its conditional store separate real reservation updates from accidental ones. A reset raised together with a reserving load shows that clearing wins. Varied acknowledge delays, unaligned addresses and both so_flag values tell the bus-hold timing and the condition-field packing apart from the completion timing.

// File: rtl/lrsc_pkg.sv
// Package: shared types for the reservation / conditional-store controller.
// Assumes one outstanding bus write at most.
package lrsc_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_WAIT_ACK
    } lrsc_state_e;
endpackage

// File: rtl/lrsc_resv.sv
// Reservation register and match logic.
// Holds a valid bit and the line address above LINE_OFF. Raises cancel in the
// same cycle for a conditional store that misses. Assumes req_fire is only
// high when the controller can accept a request.
module lrsc_resv #(
    parameter int ADDR_W   = 64,
    parameter int LINE_OFF = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic              req_load,
    input  logic              req_reserve,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              cancel
);
    localparam int LINE_W = ADDR_W - LINE_OFF;

    logic              rsv_valid;
    logic [LINE_W-1:0] rsv_line;
    logic [LINE_W-1:0] req_line;
    logic              set_rsv;
    logic              clr_rsv;

    assign req_line = req_addr[ADDR_W-1:LINE_OFF];

    // Decode set, clear and cancel from the current request.
    always_comb begin
        set_rsv = 1'b0;
        clr_rsv = 1'b0;
        cancel  = 1'b0;
        if (req_fire && req_reserve) begin
            if (req_load) begin
                set_rsv = 1'b1;
            end else begin
                clr_rsv = 1'b1;
                cancel  = !rsv_valid || (req_line != rsv_line);
            end
        end
    end

    // Hold the reservation; reset and clear win over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv_valid <= 1'b0;
            rsv_line  <= '0;
        end else if (clr_rsv) begin
            rsv_valid <= 1'b0;
        end else if (set_rsv) begin
            rsv_valid <= 1'b1;
            rsv_line  <= req_line;
        end
    end
endmodule

// File: rtl/lrsc_fsm.sv
// Request sequencer and single-beat bus master.
// Starts a bus write for stores that are not cancelled, waits for the
// acknowledge, and raises exactly one completion flag per instruction.
// Assumes the requester honours busy.
module lrsc_fsm
    import lrsc_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter int BUS_ALIGN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic              req_load,
    input  logic              req_rc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              cancel,
    input  logic              bus_ack,
    output logic              busy,
    output logic              line_we,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_adr,
    output logic [DATA_W-1:0] bus_dat,
    output logic              load_q,
    output logic              fail_q,
    output logic              slow_q,
    output logic              rc_q
);
    lrsc_state_e state;

    assign busy    = (state == ST_WAIT_ACK);
    // Cache write for a store that is allowed to proceed.
    assign line_we = req_fire && !req_load && !cancel;

    // Sequence requests, drive the bus and pulse the completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bus_cyc <= 1'b0;
            bus_stb <= 1'b0;
            bus_we  <= 1'b0;
            bus_adr <= '0;
            bus_dat <= '0;
            load_q  <= 1'b0;
            fail_q  <= 1'b0;
            slow_q  <= 1'b0;
            rc_q    <= 1'b0;
        end else begin
            load_q <= 1'b0;
            fail_q <= 1'b0;
            slow_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_fire) begin
                        if (req_load) begin
                            load_q <= 1'b1;
                            rc_q   <= 1'b0;
                        end else if (cancel) begin
                            fail_q <= 1'b1;
                            rc_q   <= req_rc;
                        end else begin
                            bus_cyc <= 1'b1;
                            bus_stb <= 1'b1;
                            bus_we  <= 1'b1;
                            bus_adr <= {req_addr[ADDR_W-1:BUS_ALIGN], {BUS_ALIGN{1'b0}}};
                            bus_dat <= req_data;
                            rc_q    <= req_rc;
                            state   <= ST_WAIT_ACK;
                        end
                    end
                end
                ST_WAIT_ACK: begin
                    if (bus_ack) begin
                        bus_cyc <= 1'b0;
                        bus_stb <= 1'b0;
                        bus_we  <= 1'b0;
                        slow_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lrsc_complete.sv
// Completion reporting.
// Merges the three completion flags into one pulse and packs the condition
// field. Assumes at most one flag is high at a time.
module lrsc_complete (
    input  logic       load_q,
    input  logic       fail_q,
    input  logic       slow_q,
    input  logic       rc_q,
    input  logic       so_flag,
    output logic       done_valid,
    output logic       done_rc,
    output logic       done_store_done,
    output logic       cr0_we,
    output logic [3:0] cr0_field
);
    // Build the completion outputs and the condition value.
    always_comb begin
        done_valid      = load_q || fail_q || slow_q;
        done_rc         = (fail_q || slow_q) && rc_q;
        done_store_done = slow_q;
        cr0_we          = done_valid && done_rc;
        cr0_field       = cr0_we ? {2'b00, done_store_done, so_flag} : 4'b0000;
    end
endmodule

// File: rtl/lrsc_ctrl.sv
// Top: reservation and conditional-store controller.
// Gates requests with stall, then ties together the reservation tracker,
// the bus sequencer and the completion logic.
module lrsc_ctrl #(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter int LINE_OFF  = 6,
    parameter int BUS_ALIGN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_load,
    input  logic              req_reserve,
    input  logic              req_rc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              so_flag,
    output logic              stall,
    output logic              line_we,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_adr,
    output logic [DATA_W-1:0] bus_dat,
    input  logic              bus_ack,
    output logic              done_valid,
    output logic              done_rc,
    output logic              done_store_done,
    output logic              cr0_we,
    output logic [3:0]        cr0_field
);
    logic req_fire;
    logic cancel;
    logic busy;
    logic load_q;
    logic fail_q;
    logic slow_q;
    logic rc_q;

    assign stall    = busy;
    assign req_fire = req_valid && !busy;

    lrsc_resv #(
        .ADDR_W   (ADDR_W),
        .LINE_OFF (LINE_OFF)
    ) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_fire    (req_fire),
        .req_load    (req_load),
        .req_reserve (req_reserve),
        .req_addr    (req_addr),
        .cancel      (cancel)
    );

    lrsc_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BUS_ALIGN (BUS_ALIGN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_fire (req_fire),
        .req_load (req_load),
        .req_rc   (req_rc),
        .req_addr (req_addr),
        .req_data (req_data),
        .cancel   (cancel),
        .bus_ack  (bus_ack),
        .busy     (busy),
        .line_we  (line_we),
        .bus_cyc  (bus_cyc),
        .bus_stb  (bus_stb),
        .bus_we   (bus_we),
        .bus_adr  (bus_adr),
        .bus_dat  (bus_dat),
        .load_q   (load_q),
        .fail_q   (fail_q),
        .slow_q   (slow_q),
        .rc_q     (rc_q)
    );

    lrsc_complete u_cmp (
        .load_q          (load_q),
        .fail_q          (fail_q),
        .slow_q          (slow_q),
        .rc_q            (rc_q),
        .so_flag         (so_flag),
        .done_valid      (done_valid),
        .done_rc         (done_rc),
        .done_store_done (done_store_done),
        .cr0_we          (cr0_we),
        .cr0_field       (cr0_field)
    );
endmodule

// File: rtl/lrsc_ctrl_chk.sv
// Checker for lrsc_ctrl: temporal properties on ports and completion flags.
// Attached to every lrsc_ctrl instance by the bind below.
module lrsc_ctrl_chk #(
    parameter int ADDR_W    = 64,
    parameter int BUS_ALIGN = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_load,
    input logic              stall,
    input logic              line_we,
    input logic              bus_cyc,
    input logic              bus_stb,
    input logic              bus_we,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_adr,
    input logic              done_valid,
    input logic              done_rc,
    input logic              done_store_done,
    input logic              cr0_we,
    input logic [3:0]        cr0_field,
    input logic              load_q,
    input logic              fail_q,
    input logic              slow_q
);
    // R13
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({load_q, fail_q, slow_q}) <= 1);

    // R8
    bus_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_adr[BUS_ALIGN-1:0] == '0) && bus_stb && bus_we);

    // R8
    stall_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc == stall);

    // R7
    line_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |-> req_valid && !req_load && !stall);

    // R10
    load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_load && !stall) |=> done_valid && !done_rc && !done_store_done);

    // R9
    ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ack) |=> done_valid && done_store_done && !bus_cyc);

    // R11
    cr_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |-> (cr0_field[3:2] == 2'b00) && (cr0_field[1] == done_store_done) && done_valid);
endmodule

bind lrsc_ctrl lrsc_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .BUS_ALIGN (BUS_ALIGN)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_load        (req_load),
    .stall           (stall),
    .line_we         (line_we),
    .bus_cyc         (bus_cyc),
    .bus_stb         (bus_stb),
    .bus_we          (bus_we),
    .bus_ack         (bus_ack),
    .bus_adr         (bus_adr),
    .done_valid      (done_valid),
    .done_rc         (done_rc),
    .done_store_done (done_store_done),
    .cr0_we          (cr0_we),
    .cr0_field       (cr0_field),
    .load_q          (load_q),
    .fail_q          (fail_q),
    .slow_q          (slow_q)
);

// File: tb/tb_lrsc_ctrl.sv
// Bench: behavioural reference model compared with the design every cycle.
module tb_lrsc_ctrl;
    localparam int AW = 64;
    localparam int DW = 64;
    localparam int LO = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_load = 1'b0;
    logic          req_reserve = 1'b0;
    logic          req_rc = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          so_flag = 1'b0;
    logic          bus_ack = 1'b0;
    logic          stall, line_we, bus_cyc, bus_stb, bus_we;
    logic [AW-1:0] bus_adr;
    logic [DW-1:0] bus_dat;
    logic          done_valid, done_rc, done_store_done, cr0_we;
    logic [3:0]    cr0_field;

    always #4 clk = ~clk;

    lrsc_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINE_OFF(LO), .BUS_ALIGN(3)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
        .req_reserve(req_reserve), .req_rc(req_rc), .req_addr(req_addr),
        .req_data(req_data), .so_flag(so_flag), .stall(stall), .line_we(line_we),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
        .bus_dat(bus_dat), .bus_ack(bus_ack), .done_valid(done_valid),
        .done_rc(done_rc), .done_store_done(done_store_done), .cr0_we(cr0_we),
        .cr0_field(cr0_field)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    started = 0;
    bit    finished = 0;

    // reference model state
    bit             m_rv = 0;
    logic [AW-LO-1:0] m_rl = '0;
    bit             m_busy = 0;
    logic [AW-1:0]  m_adr = '0;
    logic [DW-1:0]  m_dat = '0;
    bit             m_rcs = 0;
    int             m_done = 0;   // 0 none, 1 load, 2 failed store, 3 stored
    bit             m_drc = 0;
    int             nd;
    bit             ok;

    task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s (scenario %s): actual %h expected %h", rq, what, tag, act, exp);
        end
    endtask

    // Model update on each clock edge from the inputs only.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_rv = 0; m_busy = 0; m_done = 0; m_drc = 0;
        end else begin
            nd = 0;
            if (m_busy) begin
                if (bus_ack) begin m_busy = 0; nd = 3; m_drc = m_rcs; end
            end else if (req_valid) begin
                if (req_load) begin
                    nd = 1; m_drc = 0;
                    if (req_reserve) begin m_rv = 1; m_rl = req_addr[AW-1:LO]; end
                end else begin
                    ok = !req_reserve || (m_rv && (m_rl == req_addr[AW-1:LO]));
                    if (req_reserve) m_rv = 0;
                    if (ok) begin
                        m_busy = 1; m_adr = {req_addr[AW-1:3], 3'b000};
                        m_dat = req_data; m_rcs = req_rc;
                    end else begin
                        nd = 2; m_drc = req_rc;
                    end
                end
            end
            m_done = nd;
        end
    end

    // Compare mid-cycle, after inputs settle.
    always @(negedge clk) begin
        #2;
        if (started && !finished) begin
            string lw;
            bit exp_lwe, edv, esd, ecw;
            logic [3:0] ecf;
            exp_lwe = rst_n && req_valid && !req_load && !m_busy &&
                      (!req_reserve || (m_rv && m_rl == req_addr[AW-1:LO]));
            if (!req_reserve || req_load) lw = "R7";
            else if (!m_rv) lw = "R4";
            else if (m_rl == req_addr[AW-1:LO]) lw = "R2";
            else lw = "R3";
            check(lw, "line_we", line_we, exp_lwe);
            check("R8", "stall", stall, m_busy);
            check("R8", "bus_cyc", bus_cyc, m_busy);
            check("R8", "bus_stb", bus_stb, m_busy);
            check("R8", "bus_we", bus_we, m_busy);
            if (m_busy) begin
                check("R8", "bus_adr", bus_adr, m_adr);
                check("R8", "bus_dat", bus_dat, m_dat);
            end
            edv = (m_done != 0);
            esd = (m_done == 3);
            check(m_done == 1 ? "R10" : m_done == 2 ? "R3" : "R9", "done_valid", done_valid, edv);
            check(m_done == 1 ? "R10" : "R9", "done_store_done", done_store_done, esd);
            check(m_done == 1 ? "R10" : "R9", "done_rc", done_rc, edv && m_drc);
            ecw = edv && m_drc;
            ecf = ecw ? {2'b00, esd, so_flag} : 4'b0000;
            check("R11", "cr0_we", cr0_we, ecw);
            check("R11", "cr0_field", cr0_field, ecf);
        end
    end

    task automatic report();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One request, then acknowledge after dly cycles if a bus write starts.
    task automatic op(bit ld, bit rsv, bit rc, logic [63:0] a, logic [63:0] d, int dly);
        @(negedge clk);
        req_valid = 1; req_load = ld; req_reserve = rsv; req_rc = rc;
        req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 0; req_reserve = 0;
        if (bus_cyc) begin
            repeat (dly) @(negedge clk);
            bus_ack = 1;
            @(negedge clk);
            bus_ack = 0;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    localparam logic [63:0] A = 64'h0000_1234_5678_9A40;
    localparam logic [63:0] B = 64'h0000_1234_5678_9A80;

    initial begin : stim
        tag = "R1";
        repeat (3) @(negedge clk);
        #2;
        check("R1", "stall in reset", stall, 0);
        check("R1", "bus_cyc in reset", bus_cyc, 0);
        check("R1", "done_valid in reset", done_valid, 0);
        @(negedge clk); rst_n = 1;

        tag = "R4";  op(0, 1, 1, A, 64'h11, 1);          // no reservation: fail
        tag = "R10"; op(1, 0, 0, A, 0, 0);               // plain load
                     op(1, 1, 1, A, 0, 0);               // reserving load, rc ignored
        tag = "R2";  op(0, 1, 1, A + 64'h2B, 64'hDEAD_BEEF_0123_4567, 2);
        tag = "R5";  op(0, 1, 1, A, 64'h22, 0);          // consumed by success
                     op(1, 1, 0, A, 0, 0);
                     so_flag = 1;
        tag = "R3";  op(0, 1, 1, B, 64'h33, 0);          // other line
        tag = "R5";  op(0, 1, 1, A, 64'h44, 0);          // consumed by failure
        tag = "R12"; op(1, 1, 0, B, 0, 0);
                     op(0, 0, 0, A + 64'h5, 64'h55, 0);  // plain store
                     op(1, 0, 0, A, 0, 0);               // plain load
                     op(0, 1, 1, B + 64'h3F, 64'h66, 3);  // still valid: success
        tag = "R11"; op(1, 1, 0, A, 0, 0);
                     op(0, 1, 0, A, 64'h77, 0);          // rc 0: no cr write
                     so_flag = 0;
                     op(0, 1, 1, A, 64'h88, 0);          // fail, rc 1, so 0
        tag = "R8";  op(0, 0, 0, 64'hFFFF_0000_0000_0007, 64'hA5A5_5A5A_F00D_CAFE, 5);
        tag = "R6";
        @(negedge clk);
        rst_n = 0; req_valid = 1; req_load = 1; req_reserve = 1; req_addr = A;
        @(negedge clk);
        req_valid = 0; req_reserve = 0; rst_n = 1;
        op(0, 1, 1, A, 64'h99, 0);                       // must fail
        repeat (3) @(negedge clk);
        report();
    end
endmodule